// File: doc/BRIEF.md
# Multi-core wait-for-event controller

This block manages low-power waiting for a group of processor cores. Each core owns a one-bit event flag. Each core can issue four requests: a wait-for-event whose condition passed, a wait-for-event whose condition failed, a send-event, or an exception entry. The block also receives each core's interrupt lines and mask bits. From these it decides whether a waiting core may go to sleep, and it wakes sleeping cores when an interrupt condition appears.

A send-event does not write the flags of the other cores directly. It posts an event interrupt to each other core whose flag is clear. That core later takes the interrupt by raising its acknowledge, which sets its flag and clears the pending event. No vector change takes place. Because of this, a notification sent in the same cycle as a wait on another core is always seen as a wake source, and the waiting core cannot stay asleep.

Top module: `wfe_ctrl`

## Requirements
- R1: After reset, every event flag is 0, no event interrupt is pending, no core is asleep and no wake pulse is raised.
- R2: A passing wait (`wfe_go`) on an awake core whose flag is 1 clears the flag on the next edge, and the core does not sleep.
- R3: A passing wait on an awake core whose flag is 0, while `int_pend` is 1, leaves the core awake and the flag at 0.
- R4: A passing wait on an awake core whose flag is 0, while `int_pend` is 0, puts the core to sleep (`asleep`=1) on the next edge.
- R5: A failed-condition wait (`wfe_skip`) sets that core's flag to 1 and never puts the core to sleep.
- R6: A send-event sets the issuing core's flag to 1. It also sets `evt_pend` on the next edge for every other core whose flag is currently 0. Cores whose flag is already 1 get no pending event from it.
- R7: An acknowledge (`evt_ack`) sets the core's flag to 1 and clears its pending event. A new posting in the same cycle keeps the pending event set.
- R8: An exception entry sets the core's flag to 1 on the next edge.
- R9: `int_pend` is 1 when any of these holds: IRQ with its mask clear, FIQ with its mask clear, abort with its mask clear, reset request, or a pending event. The reset request and the pending event ignore all masks.
- R10: `take_rst` follows the reset request. `take_evt` is 1 only when an event is pending, no reset is requested and no unmasked IRQ, FIQ or abort is present. Reset therefore wins over the event.
- R11: A sleeping core whose `int_pend` is 1 is awake after the next edge and raises `wake_pulse` for exactly that one cycle.
- R12: If a core executes a sleeping wait in the same cycle as another core's send-event, the core sleeps for one cycle and then wakes with a wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfe_go | input | NCORE | Wait-for-event executed, condition passed |
| wfe_skip | input | NCORE | Wait-for-event executed, condition failed |
| sev_req | input | NCORE | Send-event executed |
| exc_entry | input | NCORE | Core enters an exception |
| evt_ack | input | NCORE | Core takes its pending event interrupt |
| irq | input | NCORE | IRQ line per core |
| fiq | input | NCORE | FIQ line per core |
| abt | input | NCORE | Asynchronous abort line per core |
| rst_req | input | NCORE | Reset request per core |
| irq_mask | input | NCORE | IRQ mask bit |
| fiq_mask | input | NCORE | FIQ mask bit |
| abt_mask | input | NCORE | Abort mask bit |
| evt_flag | output | NCORE | Event flag per core |
| evt_pend | output | NCORE | Pending event interrupt per core |
| asleep | output | NCORE | Core is sleeping |
| wake_pulse | output | NCORE | One-cycle pulse on wake |
| int_pend | output | NCORE | Any interrupt condition present |
| take_rst | output | NCORE | Reset selected |
| take_evt | output | NCORE | Event interrupt selected |

## Verification
The critical overlap is a sleeping wait on one core in the same cycle as a send-event from another core. The posting and the sleep both take effect on the same edge. A directed case drives exactly this collision, then checks that the core is asleep with an event pending for one cycle, and awake with a wake pulse one cycle later. A long mixed sweep over four cores adds many more such overlaps, along with acknowledges that coincide with new postings. Every registered output is compared each cycle against a reference built from the requirements.

// File: rtl/wfe_ctrl.sv
module wfe_ctrl #(
  parameter int NCORE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] wfe_go,
  input  logic [NCORE-1:0] wfe_skip,
  input  logic [NCORE-1:0] sev_req,
  input  logic [NCORE-1:0] exc_entry,
  input  logic [NCORE-1:0] evt_ack,
  input  logic [NCORE-1:0] irq,
  input  logic [NCORE-1:0] fiq,
  input  logic [NCORE-1:0] abt,
  input  logic [NCORE-1:0] rst_req,
  input  logic [NCORE-1:0] irq_mask,
  input  logic [NCORE-1:0] fiq_mask,
  input  logic [NCORE-1:0] abt_mask,
  output logic [NCORE-1:0] evt_flag,
  output logic [NCORE-1:0] evt_pend,
  output logic [NCORE-1:0] asleep,
  output logic [NCORE-1:0] wake_pulse,
  output logic [NCORE-1:0] int_pend,
  output logic [NCORE-1:0] take_rst,
  output logic [NCORE-1:0] take_evt
);

  logic [NCORE-1:0] unmasked;
  logic [NCORE-1:0] post;
  logic [NCORE-1:0] set_flag;

  assign unmasked = (irq & ~irq_mask) | (fiq & ~fiq_mask) | (abt & ~abt_mask);
  assign int_pend = unmasked | rst_req | evt_pend;
  assign take_rst = rst_req;
  assign take_evt = evt_pend & ~rst_req & ~unmasked;
  assign set_flag = exc_entry | evt_ack | wfe_skip | sev_req;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    logic [NCORE-1:0] others;
    assign others  = sev_req & ~(NCORE'(1) << i);
    assign post[i] = (|others) & ~evt_flag[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        evt_flag[i]   <= 1'b0;
        evt_pend[i]   <= 1'b0;
        asleep[i]     <= 1'b0;
        wake_pulse[i] <= 1'b0;
      end else begin
        if (set_flag[i])
          evt_flag[i] <= 1'b1;
        else if (wfe_go[i] && evt_flag[i])
          evt_flag[i] <= 1'b0;
        evt_pend[i] <= post[i] | (evt_pend[i] & ~evt_ack[i]);
        if (asleep[i])
          asleep[i] <= ~int_pend[i];
        else
          asleep[i] <= wfe_go[i] & ~evt_flag[i] & ~int_pend[i];
        wake_pulse[i] <= asleep[i] & int_pend[i];
      end
    end

    a_r2_wfe_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wfe_go[i] && evt_flag[i] && !set_flag[i] && !asleep[i]) |=> (!evt_flag[i] && !asleep[i]));
    a_r3_pending_blocks_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (wfe_go[i] && !evt_flag[i] && int_pend[i] && !set_flag[i] && !asleep[i]) |=> (!asleep[i] && !evt_flag[i]));
    a_r4_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (wfe_go[i] && !evt_flag[i] && !int_pend[i] && !asleep[i]) |=> asleep[i]);
    a_r5_skip_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wfe_skip[i] && !asleep[i]) |=> (evt_flag[i] && !asleep[i]));
    a_r6_post: assert property (@(posedge clk) disable iff (!rst_n)
      post[i] |=> evt_pend[i]);
    a_r7_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ack[i] && !post[i]) |=> (evt_flag[i] && !evt_pend[i]));
    a_r8_exc_sets: assert property (@(posedge clk) disable iff (!rst_n)
      exc_entry[i] |=> evt_flag[i]);
    a_r11_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep[i] && int_pend[i]) |=> (!asleep[i] && wake_pulse[i]));
    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse[i] |=> !wake_pulse[i]);
  end

endmodule

// File: tb/wfe_ctrl_bench.sv
module wfe_ctrl_bench;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] wfe_go, wfe_skip, sev_req, exc_entry, evt_ack;
  logic [N-1:0] irq, fiq, abt, rst_req, irq_mask, fiq_mask, abt_mask;
  logic [N-1:0] evt_flag, evt_pend, asleep, wake_pulse, int_pend, take_rst, take_evt;
  logic [N-1:0] m_flag, m_pend, m_sleep, m_wake;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wfe_ctrl #(.NCORE(N)) u_wfe_ctrl (
    .clk(clk), .rst_n(rst_n), .wfe_go(wfe_go), .wfe_skip(wfe_skip), .sev_req(sev_req),
    .exc_entry(exc_entry), .evt_ack(evt_ack), .irq(irq), .fiq(fiq), .abt(abt),
    .rst_req(rst_req), .irq_mask(irq_mask), .fiq_mask(fiq_mask), .abt_mask(abt_mask),
    .evt_flag(evt_flag), .evt_pend(evt_pend), .asleep(asleep), .wake_pulse(wake_pulse),
    .int_pend(int_pend), .take_rst(take_rst), .take_evt(take_evt));

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_in();
    {wfe_go, wfe_skip, sev_req, exc_entry, evt_ack} = '0;
    {irq, fiq, abt, rst_req, irq_mask, fiq_mask, abt_mask} = '0;
  endtask

  task automatic cyc();
    logic [N-1:0] um, pa, nf, np, ns, nw;
    @(negedge clk);
    um = (irq & ~irq_mask) | (fiq & ~fiq_mask) | (abt & ~abt_mask);
    pa = um | rst_req | m_pend;
    chk("R9 int_pend", int_pend, pa);
    chk("R10 take_rst", take_rst, rst_req);
    chk("R10 take_evt", take_evt, m_pend & ~rst_req & ~um);
    for (int i = 0; i < N; i++) begin
      logic others;
      others = 1'b0;
      for (int j = 0; j < N; j++) if (j != i && sev_req[j]) others = 1'b1;
      if (exc_entry[i] | evt_ack[i] | wfe_skip[i] | sev_req[i]) nf[i] = 1'b1;
      else if (wfe_go[i] && m_flag[i]) nf[i] = 1'b0;
      else nf[i] = m_flag[i];
      np[i] = (others & ~m_flag[i]) | (m_pend[i] & ~evt_ack[i]);
      ns[i] = m_sleep[i] ? ~pa[i] : (wfe_go[i] & ~m_flag[i] & ~pa[i]);
      nw[i] = m_sleep[i] & pa[i];
    end
    @(posedge clk); #1;
    m_flag = nf; m_pend = np; m_sleep = ns; m_wake = nw;
    chk("R2/R5/R6/R7/R8 evt_flag", evt_flag, m_flag);
    chk("R6/R7 evt_pend", evt_pend, m_pend);
    chk("R3/R4 asleep", asleep, m_sleep);
    chk("R11 wake_pulse", wake_pulse, m_wake);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_in();
    m_flag = '0; m_pend = '0; m_sleep = '0; m_wake = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 flag reset", evt_flag, '0);
    chk("R1 pend reset", evt_pend, '0);
    chk("R1 asleep reset", asleep, '0);
    chk("R1 wake reset", wake_pulse, '0);

    // R4 then R12: core0 sleeps; core0 sleeps while core1 sends
    wfe_go = 4'b0001; cyc(); clear_in();
    chk("R4 core0 asleep", asleep, 4'b0001);
    irq = 4'b0001; irq_mask = 4'b0001; cyc();
    chk("R9 masked irq keeps sleep", asleep, 4'b0001);
    irq = 4'b0001; irq_mask = 4'b0000; cyc(); clear_in();
    chk("R11 wake", wake_pulse, 4'b0001);
    cyc();
    chk("R11 pulse ends", wake_pulse, 4'b0000);
    wfe_go = 4'b0100; sev_req = 4'b0010; cyc(); clear_in();
    chk("R12 sleeps one cycle", asleep & 4'b0100, 4'b0100);
    chk("R12 event posted", evt_pend & 4'b0100, 4'b0100);
    cyc();
    chk("R12 woken", asleep & 4'b0100, 4'b0000);
    chk("R12 wake pulse", wake_pulse & 4'b0100, 4'b0100);
    evt_ack = evt_pend; cyc(); clear_in();
    chk("R7 ack clears", evt_pend, 4'b0000);
    // R2: flag 1 then wait clears it, no sleep
    wfe_go = 4'b1111; cyc(); clear_in();
    chk("R2 no sleep with flag set", asleep, 4'b0000);
    // R3: pending reset blocks sleep, evt not chosen over reset
    wfe_go = 4'b1111; rst_req = 4'b1111; cyc(); clear_in();
    chk("R3 pending blocks sleep", asleep, 4'b0000);
    // R5: skipped wait
    wfe_skip = 4'b1010; cyc(); clear_in();
    chk("R5 skip sets flag", evt_flag & 4'b1010, 4'b1010);

    // near-exhaustive mixed sweep
    for (int k = 0; k < 6000; k++) begin
      clear_in();
      for (int i = 0; i < N; i++) begin
        int r;
        r = $urandom % 24;
        case (r)
          0, 1, 2, 3, 4, 5: wfe_go[i] = 1'b1;
          6: wfe_skip[i] = 1'b1;
          7: sev_req[i] = 1'b1;
          8: exc_entry[i] = 1'b1;
          default: ;
        endcase
        if (m_pend[i] && ($urandom % 3 == 0)) evt_ack[i] = 1'b1;
        irq[i] = ($urandom % 8) == 0;
        fiq[i] = ($urandom % 10) == 0;
        abt[i] = ($urandom % 12) == 0;
        rst_req[i] = ($urandom % 40) == 0;
        irq_mask[i] = $urandom % 2;
        fiq_mask[i] = $urandom % 2;
        abt_mask[i] = $urandom % 2;
      end
      cyc();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule